// File: doc/BRIEF.md
# Hint-Driven Clock Gate Controller

This block produces gated clocks for two groups of units inside one clock domain. Peripheral units get a clock that software switches on and off with an enable register. Transactional units get a clock that software only advises on with a hint register. A busy unit keeps its clock running until it reports idle, even after the hint has been withdrawn.

Both groups also obey a clock-enable input from the power controller. A multi-bit scan-mode input forces every gated clock to run. Each output passes through a glitch-free gate. The gate captures its enable in a level-sensitive latch that is open only while the source clock is low.

Software reaches the two registers through a single-cycle write port and a combinational read port. Register address 0 holds the peripheral enables and address 1 holds the transactional hints.

Top module: `clk_hint_gate`

## Requirements
- R1: After reset, every peripheral enable bit and every transactional hint bit reads back as 1, and all gated clocks are stopped until the first enable evaluation after reset.
- R2: A write with `reg_addr_i` = 0 loads the peripheral enables from the low bits of `reg_wdata_i`, and a write with address 1 loads the hints. The read port returns the register that `reg_addr_i` selects, with the bits above the register width reading as 0.
- R3: A peripheral clock runs only when its enable bit and `pwr_clk_en_i` are both 1. A write accepted at rising edge N changes the gated clock from the high phase that starts at edge N+2.
- R4: A transactional clock runs whenever its hint bit is 1 and `pwr_clk_en_i` is 1, whatever its idle input is.
- R5: A transactional clock with its hint bit at 0 keeps running while the unit's idle input is 0.
- R6: A transactional clock with its hint bit at 0 stops once the unit's idle input is 1.
- R7: With `pwr_clk_en_i` at 0 and scan mode not On, every peripheral and transactional clock is stopped, whatever the register bits and idle inputs are.
- R8: Scan mode is On only for `scan_mode_i` = 4'b0101. While it is On, every gated clock runs regardless of registers, idle inputs and the power enable. Every other code, including codes one bit away from 4'b0101, counts as not On.
- R9: Each gated clock is low whenever the source clock is low. Its enable is taken only while the source clock is low, so it never produces a partial high pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_clk_en_i | input | 1 | Clock enable from the power controller |
| scan_mode_i | input | 4 | Multi-bit scan mode, On = 4'b0101 |
| unit_idle_i | input | NUM_TRANS | Per-unit idle indication of the transactional units |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 peripheral enables, 1 hints |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data of the selected register |
| clk_peri_o | output | NUM_PERI | Gated peripheral clocks |
| clk_trans_o | output | NUM_TRANS | Gated transactional clocks |

## Verification
The peripheral group is first driven with an all-zero enable pattern and then its complement. This separates bits that follow the register from bits stuck at their reset value, and it shows the two-edge write latency. The transactional group is swept through hint and idle combinations: hint set with the unit idle, hint cleared with the unit busy, and idle raised one unit at a time. These separate the "hint or busy" rule from a plain hint enable. Power-off and scan codes 4'b0101, 4'b0100 and 4'b1010 are applied with all registers cleared, so that a forced clock can be told apart from a register-enabled one and a near-miss code can be told apart from On.

// File: rtl/clk_hint_gate.sv
module clk_hint_gate #(
  parameter int NUM_PERI  = 4,
  parameter int NUM_TRANS = 3,
  parameter int DATA_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_clk_en_i,
  input  logic [3:0]           scan_mode_i,
  input  logic [NUM_TRANS-1:0] unit_idle_i,
  input  logic                 reg_we_i,
  input  logic                 reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [NUM_PERI-1:0]  clk_peri_o,
  output logic [NUM_TRANS-1:0] clk_trans_o
);

  localparam logic [3:0] SCAN_ON = 4'b0101;

  logic [NUM_PERI-1:0]  peri_en_q, peri_gate_q, peri_lat;
  logic [NUM_TRANS-1:0] hint_q, trans_gate_q, trans_lat;
  logic [1:0]           up_cnt;
  logic                 scan_on;

  assign scan_on = (scan_mode_i == SCAN_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peri_en_q <= '1;
      hint_q    <= '1;
    end else if (reg_we_i) begin
      if (reg_addr_i) hint_q    <= reg_wdata_i[NUM_TRANS-1:0];
      else            peri_en_q <= reg_wdata_i[NUM_PERI-1:0];
    end
  end

  assign reg_rdata_o = reg_addr_i ? DATA_W'(hint_q) : DATA_W'(peri_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peri_gate_q  <= '0;
      trans_gate_q <= '0;
    end else begin
      peri_gate_q  <= pwr_clk_en_i ? peri_en_q : '0;
      trans_gate_q <= pwr_clk_en_i ? (hint_q | ~unit_idle_i) : '0;
    end
  end

  always_latch begin
    if (!clk_i) begin
      peri_lat  <= peri_gate_q  | {NUM_PERI{scan_on}};
      trans_lat <= trans_gate_q | {NUM_TRANS{scan_on}};
    end
  end

  assign clk_peri_o  = {NUM_PERI{clk_i}}  & peri_lat;
  assign clk_trans_o = {NUM_TRANS{clk_i}} & trans_lat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              up_cnt <= '0;
    else if (up_cnt != 2'd3)  up_cnt <= up_cnt + 2'd1;
  end

  AST_PWR_OFF_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt != 2'd0 && !$past(pwr_clk_en_i)) |-> (peri_gate_q == '0 && trans_gate_q == '0)); // R7

  AST_BUSY_KEEPS_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt != 2'd0 && $past(pwr_clk_en_i)) |->
      ((trans_gate_q & ~$past(unit_idle_i)) == ~$past(unit_idle_i))); // R5

  AST_IDLE_UNHINTED_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt != 2'd0) |-> ((trans_gate_q & $past(unit_idle_i & ~hint_q)) == '0)); // R6

  AST_HINT_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt != 2'd0 && $past(pwr_clk_en_i)) |-> ((trans_gate_q & $past(hint_q)) == $past(hint_q))); // R4

  AST_WRITE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt[1] && $past(reg_we_i && !reg_addr_i, 2) && !$past(reg_we_i && !reg_addr_i)
      && $past(pwr_clk_en_i)) |-> (peri_gate_q == $past(reg_wdata_i[NUM_PERI-1:0], 2))); // R3

  always_comb begin
    if (!clk_i) AST_LOW_PHASE_QUIET: assert ((clk_peri_o == '0) && (clk_trans_o == '0)); // R9
  end

endmodule

// File: tb/clk_hint_gate_tb_top.sv
module clk_hint_gate_tb_top;
  localparam int  NP = 4;
  localparam int  NT = 3;
  localparam int  DW = 8;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr = 1'b0;
  logic [3:0]    scan = 4'b0000;
  logic [NT-1:0] idle = '0;
  logic          we = 1'b0;
  logic          addr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NP-1:0] cper;
  logic [NT-1:0] ctr;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  bit [NP-1:0] m_per;
  bit [NT-1:0] m_hint;
  bit [NP-1:0] m_gper;
  bit [NT-1:0] m_gtr;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_hint_gate #(.NUM_PERI(NP), .NUM_TRANS(NT), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_clk_en_i(pwr), .scan_mode_i(scan),
    .unit_idle_i(idle), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .clk_peri_o(cper), .clk_trans_o(ctr));

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: evaluated at each rising edge with inputs held since the previous falling edge
  initial begin
    forever begin
      bit          forced;
      bit [NP-1:0] e_per;
      bit [NT-1:0] e_tr;
      bit [DW-1:0] e_rd;
      @(posedge clk);
      if (!rst_n) begin
        m_per = '1; m_hint = '1; m_gper = '0; m_gtr = '0;
      end else begin
        forced = (scan == 4'b0101);
        e_per  = m_gper | {NP{forced}};
        e_tr   = m_gtr  | {NT{forced}};
        m_gper = '0;
        m_gtr  = '0;
        if (pwr) begin
          m_gper = m_per;
          for (int i = 0; i < NT; i++) m_gtr[i] = m_hint[i] || !idle[i];
        end
        if (we) begin
          if (addr) m_hint = wdata[NT-1:0];
          else      m_per  = wdata[NP-1:0];
        end
        e_rd = addr ? DW'(m_hint) : DW'(m_per);
        #1;
        check(cur_req, "peripheral clocks", int'(cper), int'(e_per));
        check(cur_req, "transactional clocks", int'(ctr), int'(e_tr));
        check(cur_req, "read data", int'(rdata), int'(e_rd));
      end
    end
  end

  // R9: outputs low in every low phase
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) check("R9", "low-phase outputs", int'({cper, ctr}), 0);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cur_req = "R1";
    @(negedge clk); addr = 1'b0;
    #2 check("R1", "reset peripheral enables", int'(rdata), 'hF);
    check("R1", "clocks stopped before first evaluation", int'({cper, ctr}), 0);
    addr = 1'b1;
    #1 check("R1", "reset hints", int'(rdata), 'h7);
    pwr = 1'b1;
    cycles(4);

    cur_req = "R2";
    wr(1'b0, 8'hA5);
    addr = 1'b0; cycles(1);
    addr = 1'b1; cycles(1);
    wr(1'b1, 8'hFA);
    cycles(2);

    cur_req = "R3";
    wr(1'b0, 8'h00);
    cycles(3);
    wr(1'b0, 8'h0F);
    cycles(3);
    wr(1'b0, 8'h06);
    cycles(3);

    cur_req = "R4";
    idle = 3'b111;
    wr(1'b1, 8'h07);
    cycles(3);

    cur_req = "R5";
    idle = 3'b000;
    wr(1'b1, 8'h00);
    cycles(4);

    cur_req = "R6";
    for (int i = 0; i < NT; i++) begin
      idle[i] = 1'b1;
      cycles(3);
    end
    wr(1'b1, 8'h02);
    cycles(3);
    idle = 3'b101;
    cycles(3);

    cur_req = "R7";
    wr(1'b0, 8'h0F);
    wr(1'b1, 8'h07);
    idle = 3'b000;
    cycles(2);
    pwr = 1'b0;
    cycles(4);
    pwr = 1'b1;
    cycles(3);

    cur_req = "R8";
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    idle = 3'b111;
    pwr = 1'b0;
    cycles(3);
    scan = 4'b0101;
    cycles(4);
    scan = 4'b0100;
    cycles(3);
    scan = 4'b1010;
    cycles(3);
    scan = 4'b0101;
    pwr = 1'b1;
    cycles(2);
    scan = 4'b0000;
    cycles(3);

    finish_run();
  end
endmodule